// File: doc/BRIEF.md
# Endpoint Maximum Packet Size Guard

This block sits beside the FIFO of one bulk or interrupt endpoint of a USB device controller. It holds the endpoint's maximum packet size, which the local microcontroller programs as a low byte and a high byte. It counts the bytes that pass on the receive and transmit data paths. The FIFO storage, the PHY, token decoding and CRC checking are outside it. It only observes and gates the byte flow.

In receive mode the block counts the data bytes of each OUT packet. At end of packet it either announces a good packet or refuses it. A packet longer than the programmed maximum is refused with a sticky stall flag and a STALL handshake request. It is never cut short and delivered. In transmit mode it counts bytes written by a DMA engine. Once exactly the maximum has been loaded it arms transmission by itself. A short packet is armed only by an explicit write from the microcontroller.

Both byte paths use valid/ready. A byte moves in any cycle where both are high. When ready is low the source must hold the byte, and the block does not count it. The receive path is ready whenever the endpoint is in receive mode. The DMA path drops ready while a packet is armed, when the loaded count has reached the maximum, and whenever the endpoint is in receive mode.

Top module: `usb_pktsize_guard`

## Requirements
- R1: After a hardware reset (rst_n low) or a synchronous bus_reset, the size reads 0 at both size addresses (0 = low byte, 1 = high byte). The status register (address 2) reads 0, and the mode register (address 3) reads 0, which means receive mode.
- R2: A write to address 0 sets size bits 7:0. A write to address 1 sets size bits SIZE_W-1:8. Readback returns those bits, and the high-byte bits above SIZE_W-9 read as 0.
- R3: In receive mode, a packet of N data bytes with N less than or equal to the size, zero included, raises rx_pkt_ready for exactly one cycle. That cycle is the one after rx_eop. stall_req and stall_flag stay low.
- R4: In receive mode, a packet with N greater than the size raises stall_req for one cycle, in the cycle after rx_eop. It sets stall_flag (status bit 0), and rx_pkt_ready stays low.
- R5: The receive count saturates at size+1, so a packet of any length above the size is refused. For example, 2048 bytes against a size of 1 is refused.
- R6: stall_flag stays set until a write of 1 to status bit 0. While it is set, every OUT packet gets stall_req and no rx_pkt_ready, even if the packet has a legal length.
- R7: rx_pkt_start clears the receive count, so each packet is judged on its own bytes only.
- R8: In transmit mode (mode bit 0 = 1), tx_pkt_ready rises in the cycle after the DMA byte that brings the count to the size. Exactly size bytes are accepted.
- R9: Fewer than size DMA bytes never arm. Writing 1 to status bit 1 in transmit mode sets tx_pkt_ready. Status bit 1 reads back tx_pkt_ready.
- R10: A pulse on in_done while tx_pkt_ready is set clears tx_pkt_ready and the transmit count, so the next packet again needs size bytes.
- R11: In transmit mode rx_ready is low, and rx_eop produces neither rx_pkt_ready nor stall_req. In receive mode dma_ready is low.
- R12: dma_ready is low while tx_pkt_ready is set, and bytes offered then are not counted. With a size of 0, no DMA byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_reset | input | 1 | Synchronous USB bus reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| rx_pkt_start | input | 1 | Start of an OUT DATA packet |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte accepted |
| rx_eop | input | 1 | End of the OUT DATA packet |
| rx_pkt_ready | output | 1 | Good packet received, one-cycle pulse |
| stall_req | output | 1 | Request to answer STALL, one-cycle pulse |
| stall_flag | output | 1 | Sticky stall status |
| dma_valid | input | 1 | DMA byte valid |
| dma_ready | output | 1 | DMA byte accepted |
| in_done | input | 1 | IN transaction completed |
| tx_pkt_ready | output | 1 | Transmit packet armed |

## Verification
The receive side is swept across sizes 0, 1, 2, 5, 31, 64, 300 and 1023. For each size, packets of length 0, size-1, size, size+1 and size+2 are sent. This separates an off-by-one in the comparison from a wrong boundary direction. It also shows whether the high byte takes part in the size. A 2048-byte packet against a size of 1 shows whether the counter saturates or wraps. Back-to-back packets without a clear show whether the stall is sticky and whether the count restarts per packet. The transmit side is swept over sizes 1, 2, 7, 33 and 256 with dma_valid held high. Counting accepted bytes separates auto-arming at exactly the size from arming one byte early or late. Short loads followed by an explicit arm, in_done, and a size of 0 cover the remaining arming paths.

// File: rtl/pktguard_pkg.sv
package pktguard_pkg;
  typedef enum logic [1:0] {
    RA_SIZE_LO = 2'd0,
    RA_SIZE_HI = 2'd1,
    RA_STATUS  = 2'd2,
    RA_MODE    = 2'd3
  } reg_addr_e;

  localparam int STAT_STALL_BIT = 0;
  localparam int STAT_ARM_BIT   = 1;
  localparam int MODE_TX_BIT    = 0;
endpackage

// File: rtl/pg_cfg_regs.sv
module pg_cfg_regs
  import pktguard_pkg::*;
#(
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              stall_flag,
  input  logic              tx_ready,
  output logic [SIZE_W-1:0] max_size,
  output logic              tx_mode,
  output logic              stall_clr,
  output logic              arm_req,
  output logic [7:0]        rdata
);
  localparam int HI_W = SIZE_W - 8;

  logic [7:0] lo_q;
  logic       mode_q;
  logic [7:0] hi_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      mode_q <= 1'b0;
    end else if (bus_reset) begin
      lo_q   <= '0;
      mode_q <= 1'b0;
    end else if (wr) begin
      if (addr == RA_SIZE_LO) lo_q   <= wdata;
      if (addr == RA_MODE)    mode_q <= wdata[MODE_TX_BIT];
    end
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           hi_q <= '0;
        else if (bus_reset)                   hi_q <= '0;
        else if (wr && addr == RA_SIZE_HI)    hi_q <= wdata[HI_W-1:0];
      end
      assign max_size = {hi_q, lo_q};
      assign hi_rd    = {{(8-HI_W){1'b0}}, hi_q};
    end else begin : g_no_hi
      assign max_size = lo_q[SIZE_W-1:0];
      assign hi_rd    = 8'h00;
    end
  endgenerate

  assign tx_mode   = mode_q;
  assign stall_clr = wr && (addr == RA_STATUS) && wdata[STAT_STALL_BIT];
  assign arm_req   = wr && (addr == RA_STATUS) && wdata[STAT_ARM_BIT];

  always_comb begin
    unique case (addr)
      RA_SIZE_LO: rdata = lo_q;
      RA_SIZE_HI: rdata = hi_rd;
      RA_STATUS:  rdata = {6'b0, tx_ready, stall_flag};
      default:    rdata = {7'b0, mode_q};
    endcase
  end
endmodule

// File: rtl/pg_rx_check.sv
module pg_rx_check #(
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              enable,
  input  logic [SIZE_W-1:0] max_size,
  input  logic              pkt_start,
  input  logic              byte_fire,
  input  logic              eop,
  input  logic              stall_clr,
  output logic              pkt_ready,
  output logic              stall_req,
  output logic              stall_flag
);
  localparam int CNT_W = SIZE_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             oversize;
  logic             judge;

  assign limit    = {1'b0, max_size};
  assign oversize = cnt_q > limit;
  assign judge    = enable && eop;

  // Count stops one past the limit: enough to know the packet is too long.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (bus_reset || pkt_start)        cnt_q <= '0;
    else if (enable && byte_fire && cnt_q <= limit)
                                            cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_ready  <= 1'b0;
      stall_req  <= 1'b0;
      stall_flag <= 1'b0;
    end else if (bus_reset) begin
      pkt_ready  <= 1'b0;
      stall_req  <= 1'b0;
      stall_flag <= 1'b0;
    end else begin
      pkt_ready <= judge && !oversize && !stall_flag;
      stall_req <= judge && (oversize || stall_flag);
      if (judge && oversize)  stall_flag <= 1'b1;
      else if (stall_clr)     stall_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pg_tx_arm.sv
module pg_tx_arm #(
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              enable,
  input  logic [SIZE_W-1:0] max_size,
  input  logic              dma_valid,
  output logic              dma_ready,
  input  logic              in_done,
  input  logic              arm_req,
  output logic              tx_ready
);
  logic [SIZE_W-1:0] cnt_q;
  logic [SIZE_W-1:0] cnt_nxt;
  logic              fire;

  assign dma_ready = enable && !tx_ready && (cnt_q < max_size);
  assign fire      = dma_valid && dma_ready;
  assign cnt_nxt   = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      tx_ready <= 1'b0;
    end else if (bus_reset) begin
      cnt_q    <= '0;
      tx_ready <= 1'b0;
    end else if (tx_ready && in_done) begin
      cnt_q    <= '0;
      tx_ready <= 1'b0;
    end else begin
      if (fire) begin
        cnt_q <= cnt_nxt;
        if (cnt_nxt == max_size) tx_ready <= 1'b1;
      end
      if (enable && arm_req) tx_ready <= 1'b1;
    end
  end
endmodule

// File: rtl/usb_pktsize_guard.sv
module usb_pktsize_guard #(
  parameter int SIZE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_pkt_start,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic       rx_eop,
  output logic       rx_pkt_ready,
  output logic       stall_req,
  output logic       stall_flag,
  input  logic       dma_valid,
  output logic       dma_ready,
  input  logic       in_done,
  output logic       tx_pkt_ready
);
  logic [SIZE_W-1:0] max_size;
  logic              tx_mode;
  logic              stall_clr;
  logic              arm_req;

  pg_cfg_regs #(.SIZE_W(SIZE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .stall_flag (stall_flag),
    .tx_ready   (tx_pkt_ready),
    .max_size   (max_size),
    .tx_mode    (tx_mode),
    .stall_clr  (stall_clr),
    .arm_req    (arm_req),
    .rdata      (reg_rdata)
  );

  assign rx_ready = !tx_mode;

  pg_rx_check #(.SIZE_W(SIZE_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset),
    .enable     (!tx_mode),
    .max_size   (max_size),
    .pkt_start  (rx_pkt_start),
    .byte_fire  (rx_valid && rx_ready),
    .eop        (rx_eop),
    .stall_clr  (stall_clr),
    .pkt_ready  (rx_pkt_ready),
    .stall_req  (stall_req),
    .stall_flag (stall_flag)
  );

  pg_tx_arm #(.SIZE_W(SIZE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .enable    (tx_mode),
    .max_size  (max_size),
    .dma_valid (dma_valid),
    .dma_ready (dma_ready),
    .in_done   (in_done),
    .arm_req   (arm_req),
    .tx_ready  (tx_pkt_ready)
  );
endmodule

// File: rtl/pktguard_checker.sv
module pktguard_checker #(
  parameter int SIZE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_reset,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              rx_eop,
  input logic              rx_ready,
  input logic              rx_pkt_ready,
  input logic              stall_req,
  input logic              stall_flag,
  input logic              dma_valid,
  input logic              dma_ready,
  input logic              tx_pkt_ready,
  input logic [SIZE_W-1:0] max_size
);
  AST_SIZE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_reset) |-> max_size == '0);  // R1

  AST_RX_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_pkt_ready && stall_req));  // R4

  AST_RXRDY_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pkt_ready |-> $past(rx_eop) && $past(rx_ready));  // R3

  AST_STALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> stall_flag);  // R6

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && dma_ready));  // R11

  AST_ARMED_BLOCKS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pkt_ready |-> !dma_ready);  // R12

  AST_ARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pkt_ready) |->
      $past(dma_valid && dma_ready) ||
      $past(reg_wr && reg_addr == 2'd2 && reg_wdata[1]));  // R8
endmodule

bind usb_pktsize_guard pktguard_checker #(.SIZE_W(SIZE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_reset    (bus_reset),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .rx_eop       (rx_eop),
  .rx_ready     (rx_ready),
  .rx_pkt_ready (rx_pkt_ready),
  .stall_req    (stall_req),
  .stall_flag   (stall_flag),
  .dma_valid    (dma_valid),
  .dma_ready    (dma_ready),
  .tx_pkt_ready (tx_pkt_ready),
  .max_size     (max_size)
);

// File: tb/tb_usb_pktsize_guard.sv
module tb_usb_pktsize_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic rx_pkt_start = 1'b0, rx_valid = 1'b0, rx_eop = 1'b0;
  logic rx_ready, rx_pkt_ready, stall_req, stall_flag;
  logic dma_valid = 1'b0, in_done = 1'b0;
  logic dma_ready, tx_pkt_ready;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usb_pktsize_guard #(.SIZE_W(10)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_size(input int s);
    wr(2'd0, 8'(s));
    wr(2'd1, 8'(s >> 8));
  endtask

  // Sends a packet; returns with the verdict cycle visible.
  task automatic rx_packet(input int len);
    rx_pkt_start = 1'b1;
    @(negedge clk);
    rx_pkt_start = 1'b0;
    rx_valid = 1'b1;
    repeat (len) @(negedge clk);
    rx_valid = 1'b0;
    rx_eop = 1'b1;
    @(negedge clk);
    rx_eop = 1'b0;
  endtask

  task automatic rx_expect(input bit ok_pkt, input bit stalled, input string req);
    chk(rx_pkt_ready == ok_pkt, req, rx_pkt_ready, ok_pkt);
    chk(stall_req == stalled, req, stall_req, stalled);
    @(negedge clk);
    chk(rx_pkt_ready == 1'b0, {req, " pulse"}, rx_pkt_ready, 0);
  endtask

  // Offers n bytes with valid held; returns the number accepted.
  task automatic dma_offer(input int n, output int acc);
    acc = 0;
    dma_valid = 1'b1;
    for (int i = 0; i < n; i++) begin
      #1;
      if (dma_ready) acc++;
      @(negedge clk);
    end
    dma_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int acc;
    int sizes_rx[8] = '{0, 1, 2, 5, 31, 64, 300, 1023};
    int sizes_tx[5] = '{1, 2, 7, 33, 256};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 size lo", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 size hi", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 status", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 mode", v, 0);
    @(negedge clk);

    // R2 split size register and high-bit masking
    wr(2'd0, 8'hA5); wr(2'd1, 8'hFF);
    rd(2'd0, v); chk(v == 8'hA5, "R2 lo readback", v, 8'hA5);
    rd(2'd1, v); chk(v == 8'h03, "R2 hi masked", v, 8'h03);
    @(negedge clk);

    // R11 receive mode blocks DMA
    chk(dma_ready == 1'b0, "R11 dma in rx mode", dma_ready, 0);

    // R3 R4 R7 sweep of lengths around each size
    foreach (sizes_rx[k]) begin
      int s = sizes_rx[k];
      set_size(s);
      for (int d = -1; d <= 2; d++) begin
        int len = s + d;
        bit over;
        if (len < 0) continue;
        over = (len > s);
        rx_packet(len);
        rx_expect(!over, over, over ? "R4 oversize" : "R3 legal");
        chk(stall_flag == over, "R4 flag", stall_flag, over);
        if (over) begin
          wr(2'd2, 8'h01);
          chk(stall_flag == 1'b0, "R6 w1c", stall_flag, 0);
        end
      end
      rx_packet(0);
      rx_expect(1'b1, 1'b0, "R3 zero length");
    end

    // R5 saturation: 2048 bytes against size 1
    set_size(1);
    rx_packet(2048);
    rx_expect(1'b0, 1'b1, "R5 saturate");
    wr(2'd2, 8'h01);

    // R6 sticky stall; R7 count restarts per packet
    set_size(4);
    rx_packet(6);
    rx_expect(1'b0, 1'b1, "R6 set");
    rx_packet(2);
    rx_expect(1'b0, 1'b1, "R6 sticky");
    chk(stall_flag == 1'b1, "R6 still set", stall_flag, 1);
    wr(2'd2, 8'h01);
    rx_packet(3);
    rx_expect(1'b1, 1'b0, "R7 fresh count");
    rx_packet(4);
    rx_expect(1'b1, 1'b0, "R7 fresh count 2");

    // R11 transmit mode ignores receive side
    wr(2'd3, 8'h01);
    chk(rx_ready == 1'b0, "R11 rx_ready tx mode", rx_ready, 0);
    rx_packet(9);
    rx_expect(1'b0, 1'b0, "R11 eop ignored");

    // R8 R10 transmit sweep
    foreach (sizes_tx[k]) begin
      int s = sizes_tx[k];
      set_size(s);
      dma_offer(s + 4, acc);
      chk(acc == s, "R8 accepted", acc, s);
      chk(tx_pkt_ready == 1'b1, "R8 armed", tx_pkt_ready, 1);
      chk(dma_ready == 1'b0, "R12 blocked", dma_ready, 0);
      in_done = 1'b1; @(negedge clk); in_done = 1'b0;
      chk(tx_pkt_ready == 1'b0, "R10 cleared", tx_pkt_ready, 0);
    end

    // R8 exact arming cycle
    set_size(3);
    dma_offer(3, acc);
    chk(tx_pkt_ready == 1'b1, "R8 cycle after last", tx_pkt_ready, 1);
    in_done = 1'b1; @(negedge clk); in_done = 1'b0;

    // R9 short packet needs explicit arm
    set_size(8);
    dma_offer(3, acc);
    chk(tx_pkt_ready == 1'b0, "R9 short not armed", tx_pkt_ready, 0);
    chk(dma_ready == 1'b1, "R9 still open", dma_ready, 1);
    wr(2'd2, 8'h02);
    chk(tx_pkt_ready == 1'b1, "R9 arm write", tx_pkt_ready, 1);
    rd(2'd2, v); chk(v == 8'h02, "R9 status bit1", v, 2);
    @(negedge clk);
    // R12 offered bytes while armed are not counted
    dma_offer(5, acc);
    chk(acc == 0, "R12 none accepted", acc, 0);
    // R10 counter cleared by in_done
    in_done = 1'b1; @(negedge clk); in_done = 1'b0;
    dma_offer(7, acc);
    chk(tx_pkt_ready == 1'b0, "R10 seven not armed", tx_pkt_ready, 0);
    dma_offer(1, acc);
    chk(tx_pkt_ready == 1'b1, "R10 eighth arms", tx_pkt_ready, 1);
    in_done = 1'b1; @(negedge clk); in_done = 1'b0;

    // R12 size zero
    set_size(0);
    dma_offer(4, acc);
    chk(acc == 0, "R12 zero size", acc, 0);

    // R1 bus reset
    set_size(300);
    wr(2'd3, 8'h00);
    rx_packet(301);
    rx_expect(1'b0, 1'b1, "R4 pre bus reset");
    bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
    rd(2'd0, v); chk(v == 0, "R1 bus reset lo", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 bus reset hi", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 bus reset status", v, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule